// File: doc/BRIEF.md
# Packed Sub-Word Multiply-Add Unit

This block is an integer execution unit that forms `a * b + c`. The factors `a` and `b` are narrow fields cut out of 32-bit source words. Each factor is either one byte, chosen by a 2-bit lane index, or one halfword, chosen by a 2-bit halfword type. The `b` factor can come from a 16-bit immediate instead of a source word. The addend `c` is a full 32-bit word.

The raw sum can be shifted right by 7 or 15 and then clamped to the 32-bit range. Two halfword type codes are not usable:

- One code asks for a full-word factor, which the unit does not support. It raises an error flag and returns zero.
- The other code is illegal. It makes the whole operation return zero.

Inputs are captured on an input strobe. The result, the error flag and the optional zero/negative condition flags appear exactly one clock later, together with an output strobe. Instruction decode and register-file access stay outside the block. The unit only sees the decoded control bits and the operand values.

Top module: `subword_mac`

## Requirements
- R1: With `a_half`/`b_half` low, the factor is the byte `src[8*sel+7 : 8*sel]`, where `sel` is the 2-bit lane index (0 to 3).
- R2: With the half flag high, halfword type 0 selects bits 15:0 and type 1 selects bits 31:16 of the source.
- R3: Halfword type 2 on a factor in use sets `err_unsupported` to 1 and gives `result` 0. In every other case `err_unsupported` is 0.
- R4: Halfword type 3 on a factor in use gives `result` 0, whatever the shift and saturate settings. `err_unsupported` is 0 unless R3 also applies.
- R5: A signed factor is sign-extended from its selected width, and an unsigned one is zero-extended. The operation is signed when `a_signed` or `b_signed` is 1. In that case `src_c` is read as a two's-complement value, and otherwise as unsigned.
- R6: With `b_from_reg` at 0, the `b` factor is `imm`, sign-extended when `b_signed` is 1. `src_b`, `b_half` and `b_sel` then have no effect on `result` or `err_unsupported`.
- R7: `shift_sel` 1 shifts the sum right by 7 and `shift_sel` 2 shifts it right by 15. Codes 0 and 3 leave it unshifted. The shift is arithmetic for signed operations.
- R8: With `sat_en` at 1, a signed operation clamps to [-2^31, 2^31-1] and an unsigned one clamps to [0, 2^32-1]. With `sat_en` at 0, `result` is the low 32 bits of the shifted sum.
- R9: When `flag_en` is 1 with the strobe, `flag_zero` becomes (result == 0) and `flag_neg` becomes (signed operation AND result bit 31). Otherwise both flags hold their values.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `err_unsupported` hold their values while no strobe arrives.
- R11: A synchronous active-low reset clears `out_valid`, `result`, `err_unsupported`, `flag_zero` and `flag_neg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe; inputs are captured on this cycle |
| src_a | input | 32 | Source word for factor a |
| src_b | input | 32 | Source word for factor b |
| src_c | input | 32 | Addend |
| imm | input | 16 | Immediate used as factor b |
| a_signed | input | 1 | Factor a is signed |
| b_signed | input | 1 | Factor b (word lane or immediate) is signed |
| a_half | input | 1 | Factor a is a halfword (1) or a byte (0) |
| b_half | input | 1 | Factor b is a halfword (1) or a byte (0) |
| a_sel | input | 2 | Byte lane index or halfword type for a |
| b_sel | input | 2 | Byte lane index or halfword type for b |
| b_from_reg | input | 1 | Take b from src_b (1) or from imm (0) |
| shift_sel | input | 2 | Post-add shift: 1 gives 7, 2 gives 15, else none |
| sat_en | input | 1 | Clamp result to the 32-bit range |
| flag_en | input | 1 | Update condition flags with this operation |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered result |
| flag_zero | output | 1 | Zero condition flag |
| flag_neg | output | 1 | Negative condition flag |
| err_unsupported | output | 1 | Full-word halfword type was requested |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, a 16-bit immediate and shift amounts of 7 and 15.

With 16-bit halfword factors and a full-scale 32-bit addend, both ends of the signed clamp and the upper end of the unsigned clamp can be reached. This is how the saturation paths of R8 are exercised next to the plain truncation case.

All four byte lanes and all four halfword type codes are reachable on both factors. The immediate path is crossed with illegal and unsupported codes left on the `b` lane fields, to show that those fields are ignored.

// File: rtl/smac_pkg.sv
// Package: shared encodings for the sub-word multiply-add unit.
// Assumes: the halfword type and shift codes are 2 bits wide.
package smac_pkg;

    // Halfword type codes used when a factor is a halfword.
    typedef enum logic [1:0] {
        HT_LOW  = 2'd0,
        HT_HIGH = 2'd1,
        HT_WIDE = 2'd2,
        HT_BAD  = 2'd3
    } half_type_e;

    // Post-add shift selection codes.
    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_SHORT = 2'd1,
        SH_LONG  = 2'd2,
        SH_SPARE = 2'd3
    } shift_code_e;

endpackage

// File: rtl/smac_lane.sv
// Module: smac_lane
// Picks one factor out of a source word, as a byte lane or a halfword,
// and extends it to LANE_W bits. It reports the unsupported full-word
// type and the illegal type separately.
// Assumes: DATA_W holds exactly four bytes, so a 2-bit index covers all lanes.
module smac_lane
    import smac_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 17
) (
    input  logic [DATA_W-1:0]        src,
    input  logic                     is_signed,
    input  logic                     use_half,
    input  logic [1:0]               sel,
    output logic signed [LANE_W-1:0] value,
    output logic                     unsupported,
    output logic                     illegal
);
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NBYTES = DATA_W / BYTE_W;
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [BYTE_W-1:0] byte_lane [NBYTES];
    logic [HALF_W-1:0] half_lo;
    logic [HALF_W-1:0] half_hi;
    logic [BYTE_W-1:0] byte_pick;
    logic [HALF_W-1:0] half_pick;

    // Split the source word into its byte lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
        assign byte_lane[g] = src[g*BYTE_W +: BYTE_W];
    end

    assign half_lo   = src[HALF_W-1:0];
    assign half_hi   = src[DATA_W-1:HALF_W];
    assign byte_pick = byte_lane[sel];

    // Select the halfword and decode the two unusable type codes.
    always_comb begin
        half_pick   = '0;
        unsupported = 1'b0;
        illegal     = 1'b0;
        if (use_half) begin
            case (half_type_e'(sel))
                HT_LOW:  half_pick   = half_lo;
                HT_HIGH: half_pick   = half_hi;
                HT_WIDE: unsupported = 1'b1;
                default: illegal     = 1'b1;
            endcase
        end
    end

    // Extend the chosen field to the common factor width.
    always_comb begin
        if (use_half) begin
            value = {{(LANE_W-HALF_W){is_signed & half_pick[HALF_W-1]}}, half_pick};
        end else begin
            value = {{(LANE_W-BYTE_W){is_signed & byte_pick[BYTE_W-1]}}, byte_pick};
        end
    end

endmodule

// File: rtl/smac_arith.sv
// Module: smac_arith
// Multiplies two extended factors, adds the extended addend, applies the
// selected right shift, then clamps or truncates to DATA_W bits.
// Assumes: ACC_W is wide enough that product plus addend cannot overflow.
module smac_arith
    import smac_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LANE_W      = 17,
    parameter int unsigned ACC_W       = 50,
    parameter int unsigned SHIFT_SHORT = 7,
    parameter int unsigned SHIFT_LONG  = 15
) (
    input  logic signed [LANE_W-1:0] op_a,
    input  logic signed [LANE_W-1:0] op_b,
    input  logic [DATA_W-1:0]        addend,
    input  logic                     res_signed,
    input  logic [1:0]               shift_sel,
    input  logic                     sat_en,
    output logic [DATA_W-1:0]        out
);
    localparam logic signed [ACC_W-1:0] S_MAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] S_MIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] U_MAX =
        {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    logic signed [ACC_W-1:0] a_x;
    logic signed [ACC_W-1:0] b_x;
    logic signed [ACC_W-1:0] c_x;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] clamped;

    // Widen the factors and the addend to the accumulator width.
    always_comb begin
        a_x = {{(ACC_W-LANE_W){op_a[LANE_W-1]}}, op_a};
        b_x = {{(ACC_W-LANE_W){op_b[LANE_W-1]}}, op_b};
        c_x = {{(ACC_W-DATA_W){res_signed & addend[DATA_W-1]}}, addend};
    end

    // Multiply and accumulate at full precision.
    always_comb begin
        prod = a_x * b_x;
        sum  = prod + c_x;
    end

    // Apply the selected right shift: arithmetic if signed, logical otherwise.
    always_comb begin
        case (shift_code_e'(shift_sel))
            SH_SHORT: shifted = res_signed ? (sum >>> SHIFT_SHORT) : (sum >> SHIFT_SHORT);
            SH_LONG:  shifted = res_signed ? (sum >>> SHIFT_LONG)  : (sum >> SHIFT_LONG);
            default:  shifted = sum;
        endcase
    end

    // Clamp to the signed or unsigned 32-bit range when saturation is on.
    always_comb begin
        clamped = shifted;
        if (sat_en) begin
            if (res_signed) begin
                if (shifted > S_MAX)      clamped = S_MAX;
                else if (shifted < S_MIN) clamped = S_MIN;
            end else begin
                if (shifted > U_MAX)      clamped = U_MAX;
                else if (shifted < 0)     clamped = '0;
            end
        end
        out = clamped[DATA_W-1:0];
    end

endmodule

// File: rtl/subword_mac.sv
// Module: subword_mac (top)
// One-stage sub-word multiply-add. Inputs are captured on in_valid. The
// result, error and flags register one cycle later with out_valid.
// Assumes: the controls are already decoded, and in_valid is low during reset.
module subword_mac
    import smac_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IMM_W       = 16,
    parameter int unsigned SHIFT_SHORT = 7,
    parameter int unsigned SHIFT_LONG  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic [IMM_W-1:0]  imm,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic              a_half,
    input  logic              b_half,
    input  logic [1:0]        a_sel,
    input  logic [1:0]        b_sel,
    input  logic              b_from_reg,
    input  logic [1:0]        shift_sel,
    input  logic              sat_en,
    input  logic              flag_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              err_unsupported
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned LANE_W = HALF_W + 1;
    localparam int unsigned ACC_W  = DATA_W + HALF_W + 2;
    localparam int unsigned NOPS   = 2;

    logic [DATA_W-1:0]        lane_src    [NOPS];
    logic                     lane_signed [NOPS];
    logic                     lane_half   [NOPS];
    logic [1:0]               lane_sel    [NOPS];
    logic signed [LANE_W-1:0] lane_val    [NOPS];
    logic                     lane_unsup  [NOPS];
    logic                     lane_bad    [NOPS];

    logic signed [LANE_W-1:0] imm_val;
    logic signed [LANE_W-1:0] op_b;
    logic                     b_unsup;
    logic                     b_bad;
    logic                     res_signed;
    logic                     force_zero;
    logic                     err_next;
    logic [DATA_W-1:0]        core_out;
    logic [DATA_W-1:0]        next_result;

    assign lane_src[0]    = src_a;
    assign lane_src[1]    = src_b;
    assign lane_signed[0] = a_signed;
    assign lane_signed[1] = b_signed;
    assign lane_half[0]   = a_half;
    assign lane_half[1]   = b_half;
    assign lane_sel[0]    = a_sel;
    assign lane_sel[1]    = b_sel;

    // One lane picker per factor.
    for (genvar g = 0; g < NOPS; g++) begin : g_lane
        smac_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
            .src        (lane_src[g]),
            .is_signed  (lane_signed[g]),
            .use_half   (lane_half[g]),
            .sel        (lane_sel[g]),
            .value      (lane_val[g]),
            .unsupported(lane_unsup[g]),
            .illegal    (lane_bad[g])
        );
    end

    // Choose factor b and mask the lane status when the immediate is used.
    always_comb begin
        imm_val    = {{(LANE_W-IMM_W){b_signed & imm[IMM_W-1]}}, imm};
        op_b       = b_from_reg ? lane_val[1] : imm_val;
        b_unsup    = b_from_reg & lane_unsup[1];
        b_bad      = b_from_reg & lane_bad[1];
        res_signed = a_signed | b_signed;
        err_next   = lane_unsup[0] | b_unsup;
        force_zero = err_next | lane_bad[0] | b_bad;
    end

    smac_arith #(
        .DATA_W     (DATA_W),
        .LANE_W     (LANE_W),
        .ACC_W      (ACC_W),
        .SHIFT_SHORT(SHIFT_SHORT),
        .SHIFT_LONG (SHIFT_LONG)
    ) u_arith (
        .op_a      (lane_val[0]),
        .op_b      (op_b),
        .addend    (src_c),
        .res_signed(res_signed),
        .shift_sel (shift_sel),
        .sat_en    (sat_en),
        .out       (core_out)
    );

    // Zero the result for unsupported or illegal types.
    assign next_result = force_zero ? '0 : core_out;

    // Output stage: capture the result on the strobe, flags only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            result          <= '0;
            err_unsupported <= 1'b0;
            flag_zero       <= 1'b0;
            flag_neg        <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result          <= next_result;
                err_unsupported <= err_next;
                if (flag_en) begin
                    flag_zero <= (next_result == '0);
                    flag_neg  <= res_signed & next_result[DATA_W-1];
                end
            end
        end
    end

    // R10: the output strobe follows the input strobe by exactly one cycle.
    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("out_valid missing after in_valid");
    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("out_valid without in_valid");
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(err_unsupported))
        else $error("result changed without strobe");
    // R3: a registered error always comes with a zero result.
    assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_unsupported |-> (result == '0)) else $error("error with nonzero result");
    // R4: an illegal type on a factor in use yields zero and no error on its own.
    assert_illegal_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !err_next && ((a_half && a_sel == 2'd3) ||
                                  (b_from_reg && b_half && b_sel == 2'd3))
        |=> (result == '0) && !err_unsupported) else $error("illegal type not zeroed");
    // R9: the flags hold unless an enabled strobe arrives.
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && flag_en) |=> $stable(flag_zero) && $stable(flag_neg))
        else $error("flags changed while disabled");
    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_en) |=> (flag_zero == (result == '0)))
        else $error("zero flag disagrees with result");

endmodule

// File: tb/tb_subword_mac.sv
// Scoreboard bench: the driver pushes model results into a queue, and the
// monitor pops and compares them at each out_valid.
module tb_subword_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0, src_c = '0;
    logic [15:0] imm = '0;
    logic        a_signed = 0, b_signed = 0, a_half = 0, b_half = 0;
    logic [1:0]  a_sel = '0, b_sel = '0, shift_sel = '0;
    logic        b_from_reg = 0, sat_en = 0, flag_en = 0;
    logic        out_valid, flag_zero, flag_neg, err_unsupported;
    logic [31:0] result;

    typedef struct {
        logic [31:0] res;
        logic        z, n, e;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    logic        exp_z = 0, exp_n = 0;
    logic [31:0] last_res = '0;
    logic        last_err = 0;
    logic        mon_en = 0;
    int          cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    subword_mac dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm),
        .a_signed(a_signed), .b_signed(b_signed), .a_half(a_half), .b_half(b_half),
        .a_sel(a_sel), .b_sel(b_sel), .b_from_reg(b_from_reg), .shift_sel(shift_sel),
        .sat_en(sat_en), .flag_en(flag_en), .out_valid(out_valid), .result(result),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .err_unsupported(err_unsupported)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Extract a factor as stated by R1, R2 and R5.
    function automatic longint pick(input logic [31:0] src, input logic sg, input logic hf,
                                    input logic [1:0] sel, output bit unsup, output bit bad);
        longint v = 0;
        unsup = 0;
        bad = 0;
        if (!hf) begin
            v = longint'((src >> (8 * sel)) & 32'hff);
            if (sg && v >= 128) v -= 256;
        end else begin
            case (sel)
                2'd0: v = longint'(src[15:0]);
                2'd1: v = longint'(src[31:16]);
                2'd2: unsup = 1;
                default: bad = 1;
            endcase
            if (sg && v >= 32768) v -= 65536;
        end
        return v;
    endfunction

    // Drive one operation and push its expected outcome.
    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                        input logic [15:0] im, input logic as, input logic bs,
                        input logic ah, input logic bh, input logic [1:0] asel,
                        input logic [1:0] bsel, input logic breg, input logic [1:0] sh,
                        input logic sat, input logic fen, input string tag);
        exp_t   e;
        bit     ua, ba, ub, bb;
        longint va, vb, vc, s;
        logic   rs;
        va = pick(a, as, ah, asel, ua, ba);
        vb = pick(b, bs, bh, bsel, ub, bb);
        if (!breg) begin
            vb = longint'(im);
            if (bs && vb >= 32768) vb -= 65536;
            ub = 0;
            bb = 0;
        end
        rs = as | bs;
        vc = rs ? longint'($signed(c)) : longint'({32'b0, c});
        s = va * vb + vc;
        if (sh == 2'd1) s = s >>> 7;
        else if (sh == 2'd2) s = s >>> 15;
        if (sat) begin
            if (rs) begin
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end else begin
                if (s > 64'sd4294967295) s = 64'sd4294967295;
                if (s < 0) s = 0;
            end
        end
        e.res = s[31:0];
        if (ua || ub || ba || bb) e.res = '0;
        e.e = ua | ub;
        if (fen) begin
            exp_z = (e.res == 0);
            exp_n = rs & e.res[31];
        end
        e.z = exp_z;
        e.n = exp_n;
        e.tag = tag;
        @(negedge clk);
        src_a = a; src_b = b; src_c = c; imm = im;
        a_signed = as; b_signed = bs; a_half = ah; b_half = bh;
        a_sel = asel; b_sel = bsel; b_from_reg = breg; shift_sel = sh;
        sat_en = sat; flag_en = fen; in_valid = 1'b1;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = 32'hdead_beef;
        end
    endtask

    // Monitor: compare at each result strobe; check hold otherwise (R10).
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(result == e.res, {e.tag, " result"}, result, e.res);
                    check(err_unsupported == e.e, {e.tag, " err R3"},
                          32'(err_unsupported), 32'(e.e));
                    check({flag_zero, flag_neg} == {e.z, e.n}, {e.tag, " flags R9"},
                          32'({flag_zero, flag_neg}), 32'({e.z, e.n}));
                    last_res = e.res;
                    last_err = e.e;
                end
            end else begin
                check(result == last_res && err_unsupported == last_err,
                      "R10 hold while idle", result, last_res);
            end
        end
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check({out_valid, result, flag_zero, flag_neg, err_unsupported} == '0,
              "R11 reset state", result, 32'd0);
        mon_en = 1;

        // R1: each byte lane, unsigned, b from register byte lane 0.
        for (int i = 0; i < 4; i++)
            send(32'h8a3c_1f05, 32'h0000_0003, 32'd10, 16'd0, 0, 0, 0, 0, 2'(i), 2'd0,
                 1, 2'd0, 0, 1, "R1 byte lane");
        // R2: halfword low and high.
        send(32'h1234_0056, 32'h0002_0000, 32'd1, 16'd0, 0, 0, 1, 1, 2'd0, 2'd1,
             1, 2'd0, 0, 1, "R2 half low/high");
        send(32'h0070_ffff, 32'h0000_0005, 32'd0, 16'd0, 0, 0, 1, 0, 2'd1, 2'd0,
             1, 2'd0, 0, 1, "R2 half high");
        // R5: signed byte and halfword, signed addend.
        send(32'h0000_80f0, 32'h0000_0007, 32'hffff_fff0, 16'd0, 1, 0, 0, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 1, "R5 signed byte");
        send(32'h0000_8000, 32'h0000_0003, 32'h0000_0001, 16'd0, 1, 0, 1, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 1, "R5 signed half");
        send(32'h0000_00ff, 32'h0000_00ff, 32'hffff_ff00, 16'd0, 0, 0, 0, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 1, "R5 unsigned addend");
        // R6: immediate, signed and unsigned, with bad b-lane codes ignored.
        send(32'h0000_0004, 32'hffff_ffff, 32'd0, 16'hfff0, 0, 1, 0, 1, 2'd0, 2'd3,
             0, 2'd0, 0, 1, "R6 signed imm");
        send(32'h0000_0004, 32'hffff_ffff, 32'd0, 16'hfff0, 0, 0, 0, 1, 2'd0, 2'd2,
             0, 2'd0, 0, 1, "R6 unsigned imm");
        // R7: each shift code.
        for (int i = 0; i < 4; i++)
            send(32'h0000_ff00, 32'h0, 32'h0012_3456, 16'h7abc, 1, 1, 1, 0, 2'd0, 2'd0,
                 0, 2'(i), 0, 1, "R7 shift");
        // R8: signed positive and negative clamp, unsigned clamp, truncation.
        send(32'h0000_7fff, 32'h0, 32'h7fff_ffff, 16'h7fff, 1, 1, 1, 0, 2'd0, 2'd0,
             0, 2'd0, 1, 1, "R8 sat signed max");
        send(32'h0000_8000, 32'h0, 32'h8000_0000, 16'h7fff, 1, 1, 1, 0, 2'd0, 2'd0,
             0, 2'd0, 1, 1, "R8 sat signed min");
        send(32'h0000_ffff, 32'h0, 32'hffff_ffff, 16'hffff, 0, 0, 1, 0, 2'd0, 2'd0,
             0, 2'd0, 1, 1, "R8 sat unsigned max");
        send(32'h0000_ffff, 32'h0, 32'hffff_ffff, 16'hffff, 0, 0, 1, 0, 2'd0, 2'd0,
             0, 2'd0, 0, 1, "R8 no sat truncate");
        idle(2);
        // R3: unsupported type on a and on b.
        send(32'h1111_2222, 32'h3, 32'd5, 16'd0, 0, 0, 1, 0, 2'd2, 2'd0,
             1, 2'd0, 0, 1, "R3 wide a");
        send(32'h0000_0002, 32'h3333_4444, 32'd5, 16'd0, 0, 0, 0, 1, 2'd0, 2'd2,
             1, 2'd0, 0, 1, "R3 wide b");
        // R4: illegal type with shift and saturation requested.
        send(32'h0000_7fff, 32'h0, 32'h7fff_ffff, 16'h7fff, 1, 1, 1, 0, 2'd3, 2'd0,
             0, 2'd1, 1, 1, "R4 illegal a");
        send(32'h0000_0009, 32'h0000_0009, 32'hffff_ffff, 16'h0, 1, 0, 0, 1, 2'd0, 2'd3,
             1, 2'd2, 1, 1, "R4 illegal b");
        // R9: a negative result with flags enabled, then disabled.
        send(32'h0000_00ff, 32'h0000_0001, 32'h0, 16'h0, 1, 0, 0, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 1, "R9 neg flag");
        send(32'h0, 32'h0, 32'h0, 16'h0, 0, 0, 0, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 0, "R9 flags disabled");
        idle(3);
        // Random mix covering R1, R2, R5, R7 and R8 together.
        for (int i = 0; i < 400; i++) begin
            send($urandom, $urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
                 2'($urandom), 1'($urandom), 1'($urandom), "R5 R7 R8 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);
        check(exp_q.size() == 0, "R10 all results delivered", 32'(exp_q.size()), 32'd0);

        // R11: reset after activity clears all outputs.
        send(32'h0000_00ff, 32'h0000_00ff, 32'h1, 16'h0, 1, 0, 0, 0, 2'd0, 2'd0,
             1, 2'd0, 0, 1, "R11 pre-reset");
        idle(2);
        mon_en = 0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({out_valid, result, flag_zero, flag_neg, err_unsupported} == '0,
              "R11 reset clears outputs", result, 32'd0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule